// File: doc/BRIEF.md
# Memory Paging Register with Lock

This block sits beside a CPU that has a 64 KB address space and a separate I/O space. It catches byte writes to one I/O port and holds the last accepted byte in a register that software cannot read back. From that byte it builds the memory map. The lowest 16 KB window shows one of two ROMs. The two middle windows are tied to fixed RAM banks. The top window shows any one of eight RAM banks.

The block also gives the display a bank number, which is either the normal or the shadow screen. This choice does not touch the CPU map. One bit of the byte locks the register. After the lock is set, all further port writes are dropped until reset. The map outputs follow the CPU address with no register in the path, so an address decoder or memory controller can use them in the same cycle.

Top module: `page_select_unit`

## Requirements
- R1: After reset the register holds zero. CPU window C000h–FFFFh shows RAM bank 0, window 0000h–3FFFh shows ROM 0, `disp_bank` is 5 and `locked` is 0.
- R2: A write is accepted only when `io_wr` is 1, `io_addr[15]` is 0 and `io_addr[1]` is 0. All other bits of `io_addr` are ignored. A write that fails this check leaves every output unchanged: for example port FFFDh, port 7FFFh, or `io_wr` = 0.
- R3: Bits 2:0 of an accepted byte choose the RAM bank (0–7) shown at C000h–FFFFh (`map_is_rom` = 0). This takes effect from the clock edge that samples the write.
- R4: Bit 3 of an accepted byte sets `disp_bank`: 0 gives bank 5 and 1 gives bank 7. The CPU window 4000h–7FFFh keeps showing bank 5 either way.
- R5: Bit 4 of an accepted byte chooses ROM 0 or ROM 1 for 0000h–3FFFh. For that window `map_is_rom` = 1 and `map_bank` holds the ROM number. For all other windows `map_is_rom` = 0.
- R6: 4000h–7FFFh always maps to RAM bank 5 and 8000h–BFFFh always maps to RAM bank 2, whatever the register holds.
- R7: An accepted byte with bit 5 set is stored whole, and `locked` rises. From then on every write is ignored and the map, `disp_bank` and `locked` stay as they are.
- R8: Reset clears the lock. The first accepted write after reset takes effect again.
- R9: `map_is_rom` and `map_bank` follow `cpu_addr` within the same cycle. Window edges fall at 3FFFh/4000h, 7FFFh/8000h and BFFFh/C000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O address of the current CPU cycle |
| io_wdata | input | 8 | I/O write data byte |
| io_wr | input | 1 | I/O write strobe; each cycle it is high counts as one write |
| cpu_addr | input | 16 | Memory address to translate |
| map_is_rom | output | 1 | 1 when `cpu_addr` falls in the ROM window |
| map_bank | output | 3 | ROM number or RAM bank for `cpu_addr` |
| disp_bank | output | 3 | RAM bank the display should fetch from (5 or 7) |
| locked | output | 1 | 1 once paging has been locked |

## Verification
A write sampled at a rising edge changes the register at that same edge. So `locked`, `disp_bank` and the top- and ROM-window mapping are due at the following falling edge, and that is where the bench compares them. Address translation has no register in it, so each step leaves the register fixed and moves `cpu_addr` across the window edges one nanosecond at a time. Every output is compared at each step, well before the next rising edge. The behavioural model updates on the same edge the design does, so dropped writes, writes while locked and reset are all checked in the first cycle they could show.

// File: rtl/pgsel_pkg.sv
// Package: shared field positions, window names and the stored
// configuration type for the paging register.
// Assumes: an 8-bit I/O data bus whose bits 5:0 carry all control fields.
package pgsel_pkg;

    localparam int TOP_LSB  = 0;
    localparam int TOP_W    = 3;
    localparam int SCR_BIT  = 3;
    localparam int ROM_BIT  = 4;
    localparam int LOCK_BIT = 5;
    localparam int CFG_W    = LOCK_BIT + 1;

    typedef enum logic [1:0] {
        WIN_ROM = 2'd0,
        WIN_LOW = 2'd1,
        WIN_MID = 2'd2,
        WIN_TOP = 2'd3
    } win_e;

    // Field order matches the bit positions of the written byte.
    typedef struct packed {
        logic             lock;
        logic             rom_sel;
        logic             shadow;
        logic [TOP_W-1:0] top_bank;
    } page_cfg_t;

endpackage

// File: rtl/pgsel_decode.sv
// Module: I/O port decoder. Flags a write whose address matches the
// masked pattern.
// Assumes: io_wr already marks one write per high cycle.
module pgsel_decode #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] DEC_MASK  = 16'h8002,
    parameter logic [15:0] DEC_MATCH = 16'h0000
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] MASK  = DEC_MASK[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] MATCH = DEC_MATCH[ADDR_W-1:0];

    // Compare only the decoded bits; all other address bits are don't-care.
    always_comb begin
        hit = io_wr && ((io_addr & MASK) == MATCH);
    end
endmodule

// File: rtl/pgsel_reg.sv
// Module: the write-only configuration register with its sticky lock.
// Assumes: synchronous active-low reset; a write that sets the lock
// is itself stored in full.
module pgsel_reg
    import pgsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [CFG_W-1:0] wdata,
    output page_cfg_t        cfg_q
);
    logic take;

    // Accept a decoded write only while the lock is still clear.
    always_comb begin
        take = hit && !cfg_q.lock;
    end

    // Hold the configuration; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (take) begin
            cfg_q <= page_cfg_t'(wdata);
        end
    end
endmodule

// File: rtl/pgsel_map.sv
// Module: combinational address translator from CPU address to bank.
// Assumes: four equal windows picked by the top two address bits.
module pgsel_map
    import pgsel_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BANK_W    = 3,
    parameter int LOW_FIXED = 5,
    parameter int MID_FIXED = 2
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  page_cfg_t         cfg,
    output logic              is_rom,
    output logic [BANK_W-1:0] bank
);
    localparam int WIN_MSB = ADDR_W - 1;
    localparam logic [BANK_W-1:0] LOW_B = BANK_W'(LOW_FIXED);
    localparam logic [BANK_W-1:0] MID_B = BANK_W'(MID_FIXED);

    win_e win;
    logic unused_low_addr;

    // Name the window from the top two address bits.
    always_comb begin
        win = win_e'(cpu_addr[WIN_MSB -: 2]);
    end

    assign unused_low_addr = ^cpu_addr[WIN_MSB-2:0];

    // Pick ROM or RAM bank for the current window.
    always_comb begin
        is_rom = 1'b0;
        bank   = '0;
        unique case (win)
            WIN_ROM: begin
                is_rom = 1'b1;
                bank   = BANK_W'(cfg.rom_sel);
            end
            WIN_LOW: bank = LOW_B;
            WIN_MID: bank = MID_B;
            WIN_TOP: bank = BANK_W'(cfg.top_bank);
            default: bank = '0;
        endcase
    end
endmodule

// File: rtl/page_select_unit.sv
// Module: top of the paging register. Decodes the port, stores the
// byte, drives the CPU map, the display bank and the lock flag.
// Assumes: a 16-bit I/O and memory address and an 8-bit data byte.
module page_select_unit
    import pgsel_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter int          BANK_W     = 3,
    parameter logic [15:0] DEC_MASK   = 16'h8002,
    parameter logic [15:0] DEC_MATCH  = 16'h0000,
    parameter int          LOW_FIXED  = 5,
    parameter int          MID_FIXED  = 2,
    parameter int          NORMAL_SCR = 5,
    parameter int          SHADOW_SCR = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              map_is_rom,
    output logic [BANK_W-1:0] map_bank,
    output logic [BANK_W-1:0] disp_bank,
    output logic              locked
);
    localparam logic [BANK_W-1:0] NORM_B = BANK_W'(NORMAL_SCR);
    localparam logic [BANK_W-1:0] SHAD_B = BANK_W'(SHADOW_SCR);

    logic      hit;
    page_cfg_t cfg_q;
    logic      unused_hi_data;

    assign unused_hi_data = ^io_wdata[DATA_W-1:CFG_W];

    pgsel_decode #(
        .ADDR_W   (ADDR_W),
        .DEC_MASK (DEC_MASK),
        .DEC_MATCH(DEC_MATCH)
    ) u_decode (
        .io_addr(io_addr),
        .io_wr  (io_wr),
        .hit    (hit)
    );

    pgsel_reg u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .hit  (hit),
        .wdata(io_wdata[CFG_W-1:0]),
        .cfg_q(cfg_q)
    );

    pgsel_map #(
        .ADDR_W   (ADDR_W),
        .BANK_W   (BANK_W),
        .LOW_FIXED(LOW_FIXED),
        .MID_FIXED(MID_FIXED)
    ) u_map (
        .cpu_addr(cpu_addr),
        .cfg     (cfg_q),
        .is_rom  (map_is_rom),
        .bank    (map_bank)
    );

    // Display bank and lock flag come straight from the stored byte.
    always_comb begin
        disp_bank = cfg_q.shadow ? SHAD_B : NORM_B;
        locked    = cfg_q.lock;
    end
endmodule

// File: rtl/pgsel_checker.sv
// Module: assertion checker for page_select_unit, attached by bind.
// Assumes: default 16-bit addresses and the port decode on bits 15 and 1.
module pgsel_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              map_is_rom,
    input logic [2:0]        map_bank,
    input logic [2:0]        disp_bank,
    input logic              locked,
    input logic [5:0]        cfg_bits
);
    localparam int M = ADDR_W - 1;

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    assert_locked_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(cfg_bits));

    assert_nohit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && !io_addr[15] && !io_addr[1]) |=> $stable(cfg_bits));

    assert_mid_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[M -: 2] == 2'b10) |-> (!map_is_rom && map_bank == 3'd2));

    assert_low_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[M -: 2] == 2'b01) |-> (!map_is_rom && map_bank == 3'd5));

    assert_rom_only_bottom_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[M -: 2] != 2'b00) |-> !map_is_rom);

    assert_disp_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_bank == 3'd5) || (disp_bank == 3'd7));

    assert_top_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[M -: 2] == 2'b11) |-> (map_bank == cfg_bits[2:0]));
endmodule

bind page_select_unit pgsel_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .cpu_addr  (cpu_addr),
    .map_is_rom(map_is_rom),
    .map_bank  (map_bank),
    .disp_bank (disp_bank),
    .locked    (locked),
    .cfg_bits  (cfg_q)
);

// File: tb/page_select_unit_bench.sv
module page_select_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_wdata = 8'h0;
    logic        io_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic        map_is_rom;
    logic [2:0]  map_bank;
    logic [2:0]  disp_bank;
    logic        locked;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int mreg = 0;   // behavioural model of the stored byte

    page_select_unit u_page_select_unit (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .cpu_addr(cpu_addr), .map_is_rom(map_is_rom),
        .map_bank(map_bank), .disp_bank(disp_bank), .locked(locked)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One clock: drive inputs, update the model at the edge, settle at the falling edge.
    task automatic step(input logic r, input logic [15:0] a, input logic [7:0] d, input logic w);
        rst_n = r; io_addr = a; io_wdata = d; io_wr = w;
        @(posedge clk);
        if (!r) mreg = 0;
        else if (w && !a[15] && !a[1] && ((mreg >> 5) & 1) == 0) mreg = d & 8'h3F;
        @(negedge clk);
        io_wr = 1'b0; rst_n = 1'b1;
    endtask

    // Sweep window edges in 1 ns steps and compare every output with the model.
    task automatic compare(input string tag);
        logic [15:0] pts[8] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h7FFF,
                                16'h8000, 16'hBFFF, 16'hC000, 16'hFFFF};
        chk(tag, "disp_bank", disp_bank, ((mreg >> 3) & 1) ? 7 : 5);
        chk(tag, "locked", locked, (mreg >> 5) & 1);
        foreach (pts[i]) begin
            int eb, er;
            cpu_addr = pts[i];
            #1;
            case (pts[i][15:14])
                2'd0: begin er = 1; eb = (mreg >> 4) & 1; end
                2'd1: begin er = 0; eb = 5; end
                2'd2: begin er = 0; eb = 2; end
                default: begin er = 0; eb = mreg & 7; end
            endcase
            chk(tag, $sformatf("is_rom@%h", pts[i]), map_is_rom, er);
            chk(tag, $sformatf("bank@%h", pts[i]), map_bank, eb);
        end
    endtask

    initial begin
        @(negedge clk);
        step(0, 16'h0, 8'h0, 0);
        step(0, 16'h7FFD, 8'hFF, 1);          // write during reset is dropped
        compare("R1");
        step(1, 16'h7FFD, 8'h03, 1);
        compare("R3");
        for (int b = 0; b < 8; b++) begin
            step(1, 16'h7FFD, 8'(b), 1);
            compare("R3");
        end
        step(1, 16'h7FFD, 8'h08, 1);          // shadow screen, CPU 4000h stays bank 5
        compare("R4");
        step(1, 16'h7FFD, 8'h10, 1);          // ROM 1
        compare("R5");
        step(1, 16'h7FFD, 8'h1A, 1);
        compare("R6");
        step(1, 16'hFFFD, 8'h05, 1);          // bit 15 set: ignored
        compare("R2");
        step(1, 16'h7FFF, 8'h06, 1);          // bit 1 set: ignored
        compare("R2");
        step(1, 16'h7FFD, 8'h07, 0);          // no strobe: ignored
        compare("R2");
        step(1, 16'h0000, 8'h04, 1);          // other bits are don't-care: taken
        compare("R2");
        step(1, 16'h7FFD, 8'h2E, 1);          // lock with bank 6 and shadow applied
        compare("R7");
        step(1, 16'h7FFD, 8'h11, 1);          // ignored while locked
        compare("R7");
        step(1, 16'h0000, 8'h00, 1);
        compare("R7");
        step(0, 16'h0, 8'h0, 0);
        compare("R8");
        step(1, 16'h7FFD, 8'h15, 1);          // writes take effect again
        compare("R8");
        compare("R9");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule